// File: doc/BRIEF.md
# Six-Channel Pulse Generator with Lead-In and Repeat Count

This block produces six independent pulse-width waveforms, one per output bit. Each channel is set up through a small word-addressed register bus. A control word holds three things: an enable flag, a low lead-in delay applied before the first pulse, and a period count. A timing word holds the high time and the low time, both in clock cycles. Once enabled, a channel first holds its output low for the lead-in time. It then repeats periods that start with the high phase and end with the low phase. It runs either forever or for the programmed number of periods.

Software may reprogram the timing word while a channel runs. The period already in progress finishes with the old timing, and the new timing applies from the next period on. Clearing the enable flag cuts the output to low at once and clears the channel's counters. The next enable therefore starts again with the lead-in.

Top module: `lpwm_ctrl`

## Requirements
- R1: After synchronous reset all six outputs are low and every register reads zero.
- R2: Channel n's control word is at byte address 4*n and its timing word at 0x20 + 4*n; bits 1:0 of the address are ignored. Each register reads back the last value written. Addresses whose word slot (bits 4:2) is 6 or 7 read zero, and writes to them change nothing.
- R3: In the control word, bit 31 enables the channel and bits 30:16 give the lead-in L. After the clock edge that captures the enabling write, the output stays low until the (L+1)-th following edge and rises at that edge.
- R4: In the timing word, bits 31:16 are the high time H and bits 15:0 the low time W. Each period drives H cycles high and then W cycles low, with no gap between periods.
- R5: Control bits 15:0 give the period count N. When N is 0 the periods repeat forever. When N is nonzero the output stays low after N periods, and the control word still reads back with bit 31 set.
- R6: A write that clears bit 31 forces the output low from the cycle after the capturing edge, mid-period included. A later enable restarts the channel with its lead-in.
- R7: A timing word written while the channel runs leaves the period in progress unchanged. The new H and W apply from the next period start.
- R8: H = 0 gives a constantly low output. W = 0 with H > 0 and N = 0 gives a constantly high output after the lead-in.
- R9: Channels run independently: programming or running one channel does not alter any other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counting is in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | 6 | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 6 | One waveform per channel, bit n for channel n |

## Verification
The bench targets the edges of each phase. An off-by-one in the lead-in or phase counters shifts the rising edge of the output by one cycle. A design that latched timing words at once would shorten the period in progress after a mid-run rewrite. A design that waited for the period to end before honouring a disable would keep the output high after the cleared enable. The zero-length cases also get their own checks: H = 0, W = 0, and a finite count that ends while the high phase keeps looping. A wrong terminal test there gives an extra pulse, or an output stuck high once the count is spent.

// File: rtl/lpwm_pkg.sv
`timescale 1ns/1ps
package lpwm_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 16;
    localparam int LEAD_W  = 15;
    localparam int SLOT_W  = 3;
    localparam int MAX_CH  = 1 << SLOT_W;

    typedef struct packed {
        logic              en;
        logic [LEAD_W-1:0] lead;
        logic [CNT_W-1:0]  reps;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } tmg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_DONE
    } phase_t;

    typedef struct packed {
        phase_t           ph;
        logic [CNT_W-1:0] cnt;
    } step_t;

    typedef struct packed {
        logic              tmg_bank;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.tmg_bank = a[ADDR_W-1];
        d.slot     = a[ADDR_W-2:2];
        return d;
    endfunction

    // First phase of a fresh period for a given timing word.
    function automatic step_t period_start(input tmg_t t);
        step_t s;
        if (t.hi != '0) begin
            s.ph  = PH_HIGH;
            s.cnt = t.hi - 1'b1;
        end else begin
            s.ph  = PH_LOW;
            s.cnt = (t.lo != '0) ? t.lo - 1'b1 : '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/lpwm_regs.sv
`timescale 1ns/1ps
module lpwm_regs
    import lpwm_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output ctrl_t [NUM_CH-1:0]       ctrl_q,
    output tmg_t  [NUM_CH-1:0]       tmg_q
);

    dec_t dec;
    assign dec = decode(bus_addr);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        localparam logic [SLOT_W-1:0] SLOT = SLOT_W'(c);
        logic hit;
        assign hit = bus_wr && (dec.slot == SLOT);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[c] <= '0;
                tmg_q[c]  <= '0;
            end else if (hit) begin
                if (dec.tmg_bank) tmg_q[c]  <= tmg_t'(bus_wdata);
                else              ctrl_q[c] <= ctrl_t'(bus_wdata);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.slot == SLOT_W'(i)) begin
                bus_rdata = dec.tmg_bank ? DATA_W'(tmg_q[i]) : DATA_W'(ctrl_q[i]);
            end
        end
    end

endmodule

// File: rtl/lpwm_chan.sv
`timescale 1ns/1ps
module lpwm_chan
    import lpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  tmg_t  tmg,
    output logic  pwm
);

    phase_t           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] per_q, per_d;   // completed periods
    logic [CNT_W-1:0] lo_q, lo_d;     // low time of running period
    step_t            fresh;
    logic             go_start;
    logic             wrap;
    logic             last_per;

    assign fresh    = period_start(tmg);
    assign last_per = (ctrl.reps != '0) && ((per_q + 1'b1) == ctrl.reps);

    always_comb begin
        ph_d     = ph_q;
        cnt_d    = cnt_q;
        per_d    = per_q;
        lo_d     = lo_q;
        go_start = 1'b0;
        wrap     = 1'b0;

        unique case (ph_q)
            PH_IDLE: begin
                if (ctrl.lead != '0) begin
                    ph_d  = PH_LEAD;
                    cnt_d = CNT_W'(ctrl.lead) - 1'b1;
                end else begin
                    go_start = 1'b1;
                end
            end
            PH_LEAD: begin
                if (cnt_q == '0) go_start = 1'b1;
                else             cnt_d = cnt_q - 1'b1;
            end
            PH_HIGH: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (lo_q != '0) begin
                    ph_d  = PH_LOW;
                    cnt_d = lo_q - 1'b1;
                end else begin
                    wrap = 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt_q == '0) wrap = 1'b1;
                else             cnt_d = cnt_q - 1'b1;
            end
            PH_DONE: begin
                ph_d = PH_DONE;
            end
            default: ph_d = PH_IDLE;
        endcase

        if (wrap) begin
            if (last_per) begin
                ph_d  = PH_DONE;
                cnt_d = '0;
            end else begin
                go_start = 1'b1;
                if (ctrl.reps != '0) per_d = per_q + 1'b1;
            end
        end

        if (go_start) begin
            ph_d  = fresh.ph;
            cnt_d = fresh.cnt;
            lo_d  = tmg.lo;
        end

        if (!ctrl.en) begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
            per_d = '0;
            lo_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            per_q <= '0;
            lo_q  <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            per_q <= per_d;
            lo_q  <= lo_d;
        end
    end

    // Gating with the live enable makes a disable take effect at once.
    assign pwm = (ph_q == PH_HIGH) && ctrl.en;

endmodule

// File: rtl/lpwm_ctrl.sv
`timescale 1ns/1ps
module lpwm_ctrl
    import lpwm_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    ctrl_t [NUM_CH-1:0] ctrl_q;
    tmg_t  [NUM_CH-1:0] tmg_q;

    lpwm_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q),
        .tmg_q     (tmg_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lpwm_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl_q[c]),
            .tmg  (tmg_q[c]),
            .pwm  (pwm_out[c])
        );
    end

endmodule

// File: rtl/lpwm_checker.sv
`timescale 1ns/1ps
module lpwm_checker #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [5:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] pwm_out
);

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (pwm_out == '0))
        else $error("a_r1_reset_quiet");

    // R2: unused word slots read zero
    a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr[4:2]) >= NUM_CH) |-> (bus_rdata == '0))
        else $error("a_r2_hole_reads_zero");

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic        en_sh;
        logic [14:0] lead_sh;
        logic [16:0] age;
        logic        ctl_hit;

        assign ctl_hit = bus_wr && !bus_addr[5] && (int'(bus_addr[4:2]) == c);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_sh   <= 1'b0;
                lead_sh <= '0;
                age     <= '0;
            end else begin
                if (ctl_hit) en_sh <= bus_wdata[31];
                if (ctl_hit && bus_wdata[31] && !en_sh) begin
                    age     <= '0;
                    lead_sh <= bus_wdata[30:16];
                end else if (age != '1) begin
                    age <= age + 1'b1;
                end
            end
        end

        // R6: a disabled channel never drives high
        a_r6_off_is_low: assert property (@(posedge clk) disable iff (rst)
            !en_sh |-> !pwm_out[c])
            else $error("a_r6_off_is_low");

        // R3: low during the lead-in window after enable
        a_r3_leadin_low: assert property (@(posedge clk) disable iff (rst)
            (en_sh && (age <= {2'b00, lead_sh})) |-> !pwm_out[c])
            else $error("a_r3_leadin_low");
    end

endmodule

bind lpwm_ctrl lpwm_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
);

// File: tb/lpwm_ctrl_bench.sv
`timescale 1ns/1ps
module lpwm_ctrl_bench;

    localparam int NCH  = 6;
    localparam int NVEC = 8;
    // columns: channel, lead, reps, hi, lo, samples
    localparam int VEC [NVEC][6] = '{
        '{0, 3, 0, 2, 3, 20},   // R4 basic, R3 lead-in
        '{1, 0, 2, 3, 2, 16},   // R5 two periods
        '{2, 5, 1, 1, 1, 12},   // R5 single period after lead-in
        '{3, 0, 0, 0, 4, 12},   // R8 hi = 0
        '{4, 2, 0, 3, 0, 12},   // R8 lo = 0, constant high
        '{5, 1, 3, 1, 0, 10},   // R5 count ends a lo = 0 stream
        '{0, 0, 0, 0, 0, 6},    // R8 both zero
        '{5, 4, 0, 5, 5, 30}    // R4 longer period
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lpwm_ctrl #(.NUM_CH(NCH)) u_lpwm_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [31:0] ctl_word(int en, int lead, int reps);
        return {en[0], lead[14:0], reps[15:0]};
    endfunction

    // Expected output j samples after the enable-capturing edge.
    function automatic int model(int lead, int reps, int hi, int lo, int j);
        int t, p, per;
        if (j == 0) return 0;
        t = j - 1;
        if (t < lead) return 0;
        p = t - lead;
        per = hi + lo;
        if (per == 0) per = 1;
        if (reps != 0 && (p / per) >= reps) return 0;
        return ((p % per) < hi) ? 1 : 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called and returning at a falling edge.
    task automatic wr_reg(int addr, logic [31:0] data);
        bus_wr    = 1'b1;
        bus_addr  = addr[5:0];
        bus_wdata = data;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(int addr, output logic [31:0] data);
        bus_addr = addr[5:0];
        #1;
        data = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(pwm_out == '0, "R1", int'(pwm_out), 0, "outputs after reset");
        bad = 0;
        for (int c = 0; c < NCH; c++) begin
            rd_reg(4*c, rd);      if (rd != 0) bad++;
            rd_reg(32+4*c, rd);   if (rd != 0) bad++;
        end
        check(bad == 0, "R1", bad, 0, "nonzero registers after reset");

        // R2 readback and holes
        wr_reg(8'h00, 32'h1234_5678);
        wr_reg(8'h34, 32'hABCD_0123);
        wr_reg(8'h18, 32'hFFFF_FFFF);
        wr_reg(8'h3C, 32'hFFFF_FFFF);
        rd_reg(8'h00, rd); check(rd == 32'h1234_5678, "R2", rd, 32'h1234_5678, "ctrl0 readback");
        rd_reg(8'h34, rd); check(rd == 32'hABCD_0123, "R2", rd, 32'hABCD_0123, "tmg5 readback");
        rd_reg(8'h03, rd); check(rd == 32'h1234_5678, "R2", rd, 32'h1234_5678, "low addr bits ignored");
        rd_reg(8'h18, rd); check(rd == 0, "R2", rd, 0, "hole 0x18 reads zero");
        rd_reg(8'h3C, rd); check(rd == 0, "R2", rd, 0, "hole 0x3C reads zero");
        bad = 0;
        for (int c = 1; c < NCH; c++) begin
            rd_reg(4*c, rd); if (rd != 0) bad++;
        end
        check(bad == 0 && pwm_out == '0, "R2", bad, 0, "hole writes changed state");
        wr_reg(8'h00, 32'h0);

        // Table walk: R3 R4 R5 R8
        for (int v = 0; v < NVEC; v++) begin
            int ch, ld, rp, hi, lo, n, firstj, act, exp;
            ch = VEC[v][0]; ld = VEC[v][1]; rp = VEC[v][2];
            hi = VEC[v][3]; lo = VEC[v][4]; n = VEC[v][5];
            wr_reg(4*ch, ctl_word(0, 0, 0));
            wr_reg(32+4*ch, {hi[15:0], lo[15:0]});
            wr_reg(4*ch, ctl_word(1, ld, rp));
            bad = 0; firstj = -1; act = 0; exp = 0;
            for (int j = 0; j <= n; j++) begin
                if (int'(pwm_out[ch]) != model(ld, rp, hi, lo, j) ||
                    (pwm_out & ~(NCH'(1) << ch)) != '0) begin
                    if (firstj < 0) begin
                        firstj = j; act = int'(pwm_out);
                        exp = model(ld, rp, hi, lo, j) << ch;
                    end
                    bad++;
                end
                @(negedge clk);
            end
            check(bad == 0, (rp != 0) ? "R5" : ((hi == 0 || lo == 0) ? "R8" : "R4"),
                  act, exp, $sformatf("vector %0d waveform, first bad sample %0d", v, firstj));
            if (rp != 0) begin
                rd_reg(4*ch, rd);
                check(rd == ctl_word(1, ld, rp) && pwm_out[ch] == 1'b0, "R5", rd,
                      ctl_word(1, ld, rp), "enable kept after count spent");
            end
            wr_reg(4*ch, ctl_word(0, 0, 0));
        end

        // R3 exact rising edge with lead-in 6
        wr_reg(32+4*1, {16'd2, 16'd2});
        wr_reg(4*1, ctl_word(1, 6, 0));
        begin
            int seen;
            seen = -1;
            for (int j = 0; j <= 10; j++) begin
                if (seen < 0 && pwm_out[1]) seen = j;
                @(negedge clk);
            end
            check(seen == 7, "R3", seen, 7, "sample index of first high after lead-in 6");
        end
        wr_reg(4*1, 32'h0);

        // R6 immediate stop and restart with lead-in
        wr_reg(32+4*3, {16'd3, 16'd3});
        wr_reg(4*3, ctl_word(1, 0, 0));
        @(negedge clk);                               // sample j = 1
        @(negedge clk);                               // sample j = 2
        check(pwm_out[3] == 1'b1, "R6", int'(pwm_out[3]), 1, "high before disable");
        wr_reg(4*3, ctl_word(0, 0, 0));               // now sample j = 3
        check(pwm_out[3] == 1'b0, "R6", int'(pwm_out[3]), 0, "low right after disable");
        @(negedge clk);
        @(negedge clk);
        check(pwm_out[3] == 1'b0, "R6", int'(pwm_out[3]), 0, "stays low while disabled");
        wr_reg(4*3, ctl_word(1, 2, 0));
        bad = 0;
        for (int j = 0; j <= 9; j++) begin
            if (int'(pwm_out[3]) != model(2, 0, 3, 3, j)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6", bad, 0, "restart follows lead-in then waveform");
        wr_reg(4*3, 32'h0);

        // R7 mid-run timing rewrite
        wr_reg(32+4*2, {16'd4, 16'd4});
        wr_reg(4*2, ctl_word(1, 0, 0));
        wr_reg(32+4*2, {16'd2, 16'd2});               // now sample j = 1
        bad = 0;
        for (int j = 1; j <= 14; j++) begin
            int t, e;
            t = j - 1;
            e = (t < 8) ? int'(t < 4) : int'(((t - 8) % 4) < 2);
            if (int'(pwm_out[2]) != e) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R7", bad, 0, "old period completes before new timing");
        rd_reg(32+4*2, rd);
        check(rd == {16'd2, 16'd2}, "R7", rd, {16'd2, 16'd2}, "new timing word stored");
        wr_reg(4*2, 32'h0);

        // R9 two channels at once
        wr_reg(32+4*1, {16'd2, 16'd2});
        wr_reg(32+4*4, {16'd1, 16'd3});
        wr_reg(4*1, ctl_word(1, 1, 0));
        wr_reg(4*4, ctl_word(1, 0, 0));
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            if (int'(pwm_out[1]) != model(1, 0, 2, 2, k + 1)) bad++;
            if (int'(pwm_out[4]) != model(0, 0, 1, 3, k)) bad++;
            if (pwm_out[0] || pwm_out[2] || pwm_out[3] || pwm_out[5]) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9", bad, 0, "concurrent channels mismatches");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule